// File: doc/BRIEF.md
# Double-Buffered DAC Command Register Bank

This block sits between a serial receiver and the analog part of a small multi-channel DAC. Each time the receiver finishes a 24-bit command word it raises a one-cycle valid strobe. The block decodes the word and executes it on that clock edge.

Every channel has two registers. The staging (input) register takes new codes. The active register holds the code the converter actually uses. A write fills the staging register only. An update moves the staged code to the active register and also wakes the channel from power-down. A write-and-update does both on one edge. A write-then-update-all writes one channel and then refreshes every channel. A power-down command puts the addressed channels to sleep.

The active codes and the per-channel sleep flags are driven straight out as plain outputs. The code width (12, 14 or 16 bits) and the channel count are parameters.

Top module: `dac_cmd_bank`

## Requirements
- R1: After reset every staging and active register is zero and every sleep flag is 1.
- R2: The command is bits 23:20 and the channel address is bits 19:16. The code is the top CODE_W bits of bits 15:0, with bit 15 as the code MSB. The remaining low bits of the data field are ignored.
- R3: Command 0000 loads the code into the staging register of each addressed channel. Active codes and sleep flags do not change.
- R4: Command 0001 copies each addressed channel's staging register into its active register and clears its sleep flag.
- R5: Command 0011 loads the new code into both registers of each addressed channel on the same edge and clears its sleep flag.
- R6: Command 0010 loads the addressed channel's staging register. On the same edge it copies every channel's staging register (with the new code included) into its active register and clears all sleep flags. If the address selects no channel, nothing changes.
- R7: Command 0100 sets the sleep flag of each addressed channel and keeps its active code.
- R8: Address k (k < NUM_CH) selects channel k, and address 1111 selects all channels. Any other address selects none, so the command has no effect.
- R9: Command 1111 and every command not listed above change nothing.
- R10: Nothing changes while word_valid is low. A command's effect is visible on the outputs right after the clock edge at which word_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 24 | Command, address and data field |
| active_codes | output | NUM_CH*CODE_W | Active code per channel, channel 0 in the low bits |
| chan_off | output | NUM_CH | Sleep flag per channel, 1 = powered down |

## Verification
The bench runs with a 14-bit code and data fields whose two low bits are set. A design that keeps those bits, or takes the wrong end of the field, shows a shifted code after the next update.

Write-and-update and write-then-update-all are checked for using the new code on the same edge. A design that reads the old staging value would show the previous code. The update-all case is also checked for refreshing the other channel.

Unassigned addresses, the broadcast address, and undefined and no-op commands are all sent. A design that decodes addresses loosely would alter a channel it should leave alone.

A power-down is followed by a check that the active code survives. An update is checked for clearing the sleep flag. Words presented with the strobe low must leave every output untouched.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef enum logic [3:0] {
    OP_WRITE         = 4'h0,
    OP_UPDATE        = 4'h1,
    OP_WRITE_UPD_ALL = 4'h2,
    OP_WRITE_UPD     = 4'h3,
    OP_PWR_DOWN      = 4'h4,
    OP_NOP           = 4'hF
  } dac_op_e;

  localparam logic [3:0] ADDR_BCAST = 4'hF;

  // One bit per channel (up to 15): set when the address selects that channel.
  function automatic logic [15:0] chan_select(input logic [3:0] addr, input int unsigned n_ch);
    logic [15:0] m;
    m = '0;
    for (int unsigned i = 0; i < 16; i++) begin
      if (i < n_ch && (addr == ADDR_BCAST || addr == 4'(i))) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [3:0]        op,
  input  logic [3:0]        addr,
  output logic [NUM_CH-1:0] wr_mask,
  output logic [NUM_CH-1:0] upd_mask,
  output logic [NUM_CH-1:0] pd_mask
);

  logic [15:0]       sel_full;
  logic [NUM_CH-1:0] sel;

  assign sel_full = chan_select(addr, NUM_CH);
  assign sel      = sel_full[NUM_CH-1:0];

  always_comb begin
    wr_mask  = '0;
    upd_mask = '0;
    pd_mask  = '0;
    if (valid) begin
      case (op)
        OP_WRITE:         wr_mask = sel;
        OP_UPDATE:        upd_mask = sel;
        OP_WRITE_UPD_ALL: begin
          wr_mask  = sel;
          upd_mask = (|sel) ? '1 : '0;
        end
        OP_WRITE_UPD:     begin
          wr_mask  = sel;
          upd_mask = sel;
        end
        OP_PWR_DOWN:      pd_mask = sel;
        default:          ;
      endcase
    end
  end

  // R7: a channel is never told to wake and sleep on one edge
  assert_upd_pd_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mask & pd_mask) == '0);

  // R8: an unassigned address never produces a write strobe
  assert_bad_addr_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ADDR_BCAST && addr >= 4'(NUM_CH)) |-> wr_mask == '0);

endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upd_en,
  input  logic              pd_en,
  input  logic [CODE_W-1:0] new_code,
  output logic [CODE_W-1:0] active_code,
  output logic              pwr_down
);

  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] act_q;
  logic              off_q;
  logic [CODE_W-1:0] upd_src;

  // An update on the same edge as a write takes the fresh code.
  assign upd_src = wr_en ? new_code : stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
      off_q   <= 1'b1;
    end else begin
      if (wr_en) stage_q <= new_code;
      if (upd_en) begin
        act_q <= upd_src;
        off_q <= 1'b0;
      end else if (pd_en) begin
        off_q <= 1'b1;
      end
    end
  end

  assign active_code = act_q;
  assign pwr_down    = off_q;

  // R3: a plain write leaves the active code alone
  assert_write_keeps_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !upd_en) |=> $stable(active_code));

  // R4: any update wakes the channel
  assert_update_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> !pwr_down);

  // R5: write with update lands the new code in the active register
  assert_wrupd_new_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && upd_en) |=> active_code == $past(new_code));

  // R7: power-down sleeps the channel and keeps its code
  assert_pd_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en && !upd_en) |=> (pwr_down && $stable(active_code)));

endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
  import dac_cmd_pkg::*;
#(
  parameter int unsigned CODE_W = 16,
  parameter int unsigned NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_valid,
  input  logic [23:0]              cmd_word,
  output logic [NUM_CH*CODE_W-1:0] active_codes,
  output logic [NUM_CH-1:0]        chan_off
);

  localparam int unsigned DROP_W = 16 - CODE_W;

  logic [3:0]        op_f;
  logic [3:0]        addr_f;
  logic [CODE_W-1:0] code_f;
  logic [NUM_CH-1:0] wr_mask;
  logic [NUM_CH-1:0] upd_mask;
  logic [NUM_CH-1:0] pd_mask;

  assign op_f   = cmd_word[23:20];
  assign addr_f = cmd_word[19:16];
  assign code_f = cmd_word[15 -: CODE_W];

  initial begin
    if (!(CODE_W == 12 || CODE_W == 14 || CODE_W == 16) || NUM_CH < 1 || NUM_CH > 15)
      $error("dac_cmd_bank: unsupported parameters, DROP_W=%0d", DROP_W);
  end

  dac_cmd_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (word_valid),
    .op       (op_f),
    .addr     (addr_f),
    .wr_mask  (wr_mask),
    .upd_mask (upd_mask),
    .pd_mask  (pd_mask)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dac_chan_reg #(.CODE_W(CODE_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_mask[c]),
      .upd_en      (upd_mask[c]),
      .pd_en       (pd_mask[c]),
      .new_code    (code_f),
      .active_code (active_codes[c*CODE_W +: CODE_W]),
      .pwr_down    (chan_off[c])
    );
  end

  // R10: no strobe, no change
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> ($stable(active_codes) && $stable(chan_off)));

  // R9: no-op command changes nothing
  assert_nop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && op_f == OP_NOP) |=> ($stable(active_codes) && $stable(chan_off)));

  // R6: a write-then-update-all with a valid address wakes every channel
  assert_upd_all_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && op_f == OP_WRITE_UPD_ALL && (addr_f == ADDR_BCAST || addr_f < 4'(NUM_CH)))
    |=> chan_off == '0);

endmodule

// File: tb/dac_cmd_bank_bench.sv
module dac_cmd_bank_bench;

  localparam int unsigned CW  = 14;
  localparam int unsigned NCH = 2;
  localparam time         CLK_P = 8ns;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                word_valid = 1'b0;
  logic [23:0]         cmd_word = '0;
  logic [NCH*CW-1:0]   active_codes;
  logic [NCH-1:0]      chan_off;

  int total = 0;
  int bad   = 0;

  logic [CW-1:0]     m_stage [NCH];
  logic [CW-1:0]     m_act   [NCH];
  logic [NCH-1:0]    m_off;

  logic [NCH*CW-1:0] exp_act_q [$];
  logic [NCH-1:0]    exp_off_q [$];
  string             exp_tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  dac_cmd_bank #(.CODE_W(CW), .NUM_CH(NCH)) u_dac_cmd_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .cmd_word     (cmd_word),
    .active_codes (active_codes),
    .chan_off     (chan_off)
  );

  // Reference model written from the requirements.
  task automatic model_apply(input logic [23:0] w, input logic v);
    logic [3:0] op;
    logic [3:0] ad;
    logic [CW-1:0] code;
    bit hit [NCH];
    bit any;
    op   = w[23:20];
    ad   = w[19:16];
    code = CW'(w[15:0] >> (16 - CW));
    any  = 0;
    for (int c = 0; c < NCH; c++) begin
      hit[c] = (ad == 4'hF) || (ad == 4'(c));
      any    = any | hit[c];
    end
    if (!v) return;
    for (int c = 0; c < NCH; c++) begin
      case (op)
        4'h0: if (hit[c]) m_stage[c] = code;
        4'h1: if (hit[c]) begin m_act[c] = m_stage[c]; m_off[c] = 1'b0; end
        4'h3: if (hit[c]) begin m_stage[c] = code; m_act[c] = code; m_off[c] = 1'b0; end
        4'h4: if (hit[c]) m_off[c] = 1'b1;
        default: ;
      endcase
    end
    if (op == 4'h2 && any) begin
      for (int c = 0; c < NCH; c++) if (hit[c]) m_stage[c] = code;
      for (int c = 0; c < NCH; c++) begin m_act[c] = m_stage[c]; m_off[c] = 1'b0; end
    end
  endtask

  function automatic logic [NCH*CW-1:0] model_flat();
    logic [NCH*CW-1:0] f;
    for (int c = 0; c < NCH; c++) f[c*CW +: CW] = m_act[c];
    return f;
  endfunction

  // Driver: present a word for one edge, then queue the expected outputs.
  task automatic send(input logic [23:0] w, input logic v, input string tag);
    @(negedge clk);
    cmd_word   = w;
    word_valid = v;
    @(posedge clk);
    #1;
    word_valid = 1'b0;
    model_apply(w, v);
    exp_act_q.push_back(model_flat());
    exp_off_q.push_back(m_off);
    exp_tag_q.push_back(tag);
  endtask

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk) begin
    while (exp_act_q.size() > 0) begin
      logic [NCH*CW-1:0] ea;
      logic [NCH-1:0]    eo;
      string             tg;
      ea = exp_act_q.pop_front();
      eo = exp_off_q.pop_front();
      tg = exp_tag_q.pop_front();
      total++;
      if (active_codes !== ea || chan_off !== eo) begin
        bad++;
        $display("FAIL %s: codes=%h off=%b expected codes=%h off=%b",
                 tg, active_codes, chan_off, ea, eo);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    total++;
    bad++;
    $display("FAIL watchdog R10: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_stage[c] = '0; m_act[c] = '0; end
    m_off = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    total++;
    if (active_codes !== '0 || chan_off !== '1) begin
      bad++;
      $display("FAIL R1: codes=%h off=%b expected codes=0 off=11", active_codes, chan_off);
    end

    send(24'h0_0_ABCF, 1'b1, "R3 write ch0 staging only");
    send(24'h1_0_0000, 1'b1, "R4 R2 update ch0 left-justified code");
    send(24'h0_1_1237, 1'b1, "R3 write ch1 keeps sleep");
    send(24'h3_1_FFFF, 1'b1, "R5 write+update ch1");
    send(24'h4_0_0000, 1'b1, "R7 power down ch0 keeps code");
    send(24'h3_5_7777, 1'b1, "R8 unassigned address ignored");
    send(24'h1_0_0000, 1'b1, "R8 staging untouched by bad address");
    send(24'h0_F_5557, 1'b1, "R8 broadcast write");
    send(24'h1_F_0000, 1'b1, "R8 R4 broadcast update");
    send(24'h0_1_0C03, 1'b1, "R6 stage ch1 first");
    send(24'h2_0_8001, 1'b1, "R6 write ch0 then update all");
    send(24'h4_F_0000, 1'b1, "R7 R8 broadcast power down");
    send(24'h2_9_4444, 1'b1, "R6 R8 update-all with bad address");
    send(24'hF_F_1234, 1'b1, "R9 no-op");
    send(24'h7_0_2222, 1'b1, "R9 undefined command 0111");
    send(24'h5_F_3333, 1'b1, "R9 undefined command 0101");
    send(24'h3_F_6666, 1'b0, "R10 strobe low write+update");
    send(24'h1_F_0000, 1'b1, "R10 R2 staging untouched while idle");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule